// File: doc/BRIEF.md
# Vote-Sampling Serial Receiver

This block receives asynchronous serial frames made of one start bit, eight data bits sent least significant bit first, and one stop bit. A programmable divider turns the system clock into a sampling tick at sixteen times the bit rate, so a single divider value sets the line speed, for example 57600 bit/s. The serial input passes through a two-flop synchroniser. A falling edge on the synchronised line starts the frame timing.

Every bit, the start and stop bits included, is sampled three times around its centre, one tick apart. The bit value is the majority of the three samples. A disagreement among the three samples does not get absorbed silently: it raises a noise flag for the frame. The byte is still delivered in that case, and also when the stop bit reads low, which raises a framing flag. A start bit whose majority reads high is taken as a glitch, and the receiver goes back to waiting. The received byte and both flags are held until the next strobe replaces them.

Top module: `uart_vote_rx`

## Requirements
- R1: While a frame is in progress the sampling tick comes every `div_i`+1 clocks, counted from the edge at which the start level is detected, with 16 ticks per bit. Call the first clock edge that captures the low start level into the synchroniser edge 0. Then `valid_o` is high in the cycle after edge 2+154×(`div_i`+1).
- R2: Each accepted frame gives exactly one single-cycle pulse on `valid_o`. At that pulse `data_o` holds the eight data bits, with the first received bit in bit 0.
- R3: With N = `div_i`+1, bit b of a frame (start = 0, data = 1..8, stop = 9) takes its three samples from the line levels captured at edges 16·N·b + 8N, + 9N and + 10N. The bit value is the majority of the three.
- R4: `noise_err_o` is set at the strobe when the three samples of any bit in the frame (start, data or stop) are not all equal.
- R5: A stop bit whose majority is 0 sets `frame_err_o` at the strobe, and the byte is still presented with a strobe.
- R6: A start bit whose majority is 1 abandons the frame. No strobe follows, and the receiver waits for a new falling edge.
- R7: `data_o`, `frame_err_o` and `noise_err_o` change only at a strobe. A clean frame clears both flags.
- R8: After reset `valid_o`, `data_o`, `frame_err_o` and `noise_err_o` are all 0.
- R9: The synchroniser resets to the idle high level, and a line held high never produces a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | Sampling tick period minus one, in clocks |
| rx_i | input | 1 | Asynchronous serial line, idles high |
| data_o | output | DATA_BITS | Last received byte |
| valid_o | output | 1 | One-cycle strobe per accepted frame |
| frame_err_o | output | 1 | Stop bit read low in the last frame |
| noise_err_o | output | 1 | Sample disagreement in the last frame |

## Verification
Clean frames carry every byte value at a small divider and a spread of bytes at other dividers. Together they separate bit order, tick period and strobe timing. A single-sample inversion is then swept over every bit position and each of the three sample slots. This shows that the majority keeps the data intact while the noise flag fires for start, data and stop bits alike, and that samples outside the window have no effect. Frames with a low stop bit, with and without added noise, keep the framing and noise flags apart. Short low pulses, one of them with a mid-bit low spike, must be abandoned without a strobe and must leave the next frame unharmed.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_phase_e;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic differ3(input logic a, input logic b, input logic c);
        return (a != b) || (b != c);
    endfunction

endpackage

// File: rtl/uart_sync2.sv
module uart_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [1:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= {2{RST_VAL}};
        else         sr_q <= sr_d;
    end

    assign q_o = sr_q[1];
endmodule

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    assign tick_o = run_i && (cnt_q == div_i);

    always_comb begin
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    // R1: with a divider above zero, ticks never come on back-to-back clocks
    p_tick_spacing_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && div_i != '0) ##1 $stable(div_i) |-> !tick_o);
endmodule

// File: rtl/uart_rx_vote_core.sv
module uart_rx_vote_core
    import uart_rx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OSR       = 16
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 tick_i,
    input  logic                 rx_i,
    output logic                 run_o,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 valid_o,
    output logic                 frame_err_o,
    output logic                 noise_err_o
);
    localparam int PH_W = $clog2(OSR);
    localparam int BI_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam int MID  = OSR / 2;
    localparam logic [PH_W-1:0] PH_A    = PH_W'(MID - 1);
    localparam logic [PH_W-1:0] PH_B    = PH_W'(MID);
    localparam logic [PH_W-1:0] PH_C    = PH_W'(MID + 1);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);
    localparam logic [BI_W-1:0] IDX_LAST = BI_W'(DATA_BITS - 1);

    typedef struct packed {
        rx_phase_e             st;
        logic [PH_W-1:0]       ph;
        logic [BI_W-1:0]       idx;
        logic [1:0]            smp;
        logic                  prev;
        logic                  nz;
        logic [DATA_BITS-1:0]  sh;
        logic [DATA_BITS-1:0]  data;
        logic                  valid;
        logic                  ferr;
        logic                  nerr;
    } core_t;

    core_t s_d, s_q;
    logic  maj, dis;

    always_comb begin
        maj       = vote3(s_q.smp[0], s_q.smp[1], rx_i);
        dis       = differ3(s_q.smp[0], s_q.smp[1], rx_i);
        s_d       = s_q;
        s_d.prev  = rx_i;
        s_d.valid = 1'b0;
        if (s_q.st == RX_IDLE) begin
            s_d.ph  = '0;
            s_d.smp = '0;
            if (s_q.prev && !rx_i) begin
                s_d.st  = RX_START;
                s_d.nz  = 1'b0;
                s_d.idx = '0;
            end
        end else if (tick_i) begin
            s_d.ph = (s_q.ph == PH_LAST) ? '0 : s_q.ph + 1'b1;
            if (s_q.ph == PH_A) s_d.smp[0] = rx_i;
            if (s_q.ph == PH_B) s_d.smp[1] = rx_i;
            if (s_q.ph == PH_C) begin
                unique case (s_q.st)
                    RX_START: begin
                        if (maj) begin
                            s_d.st = RX_IDLE;
                        end else begin
                            s_d.st = RX_DATA;
                            s_d.nz = dis;
                        end
                    end
                    RX_DATA: begin
                        s_d.sh = {maj, s_q.sh[DATA_BITS-1:1]};
                        s_d.nz = s_q.nz | dis;
                        if (s_q.idx == IDX_LAST) s_d.st  = RX_STOP;
                        else                     s_d.idx = s_q.idx + 1'b1;
                    end
                    RX_STOP: begin
                        s_d.data  = s_q.sh;
                        s_d.valid = 1'b1;
                        s_d.ferr  = !maj;
                        s_d.nerr  = s_q.nz | dis;
                        s_d.st    = RX_IDLE;
                    end
                    default: s_d.st = RX_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q      <= '0;
            s_q.st   <= RX_IDLE;
            s_q.prev <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign run_o       = (s_q.st != RX_IDLE);
    assign data_o      = s_q.data;
    assign valid_o     = s_q.valid;
    assign frame_err_o = s_q.ferr;
    assign noise_err_o = s_q.nerr;

    rx_phase_e       st_q;
    logic [PH_W-1:0] ph_q;
    assign st_q = s_q.st;
    assign ph_q = s_q.ph;

    // R2: the strobe lasts a single cycle
    p_strobe_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o);

    // R5: a strobe only ever follows the stop-bit decision
    p_strobe_after_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> $past(st_q) == RX_STOP);

    // R6: a start bit voted high sends the receiver back to idle
    p_false_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == RX_START && tick_i && ph_q == PH_C && maj) |=> st_q == RX_IDLE);

    // R4: disagreement on the stop bit always shows as noise at the strobe
    p_stop_noise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == RX_STOP && tick_i && ph_q == PH_C && dis) |=> (valid_o && noise_err_o));

    // R7: outputs hold between strobes
    p_hold_between_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> ($stable(data_o) && $stable(frame_err_o) && $stable(noise_err_o)));
endmodule

// File: rtl/uart_vote_rx.sv
module uart_vote_rx #(
    parameter int DATA_BITS = 8,
    parameter int OSR       = 16,
    parameter int DIV_W     = 16
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [DIV_W-1:0]     div_i,
    input  logic                 rx_i,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 valid_o,
    output logic                 frame_err_o,
    output logic                 noise_err_o
);
    logic rx_s;
    logic run;
    logic tick;

    uart_sync2 #(.RST_VAL(1'b1)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (rx_i),
        .q_o    (rx_s)
    );

    uart_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (run),
        .div_i  (div_i),
        .tick_o (tick)
    );

    uart_rx_vote_core #(.DATA_BITS(DATA_BITS), .OSR(OSR)) u_core (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tick_i      (tick),
        .rx_i        (rx_s),
        .run_o       (run),
        .data_o      (data_o),
        .valid_o     (valid_o),
        .frame_err_o (frame_err_o),
        .noise_err_o (noise_err_o)
    );

    // R9: a quiet line keeps the receiver idle, so no strobe can appear
    p_quiet_line_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run && rx_s && $past(rx_s)) |=> !run);
endmodule

// File: tb/uart_vote_rx_tb.sv
module uart_vote_rx_tb;
    localparam int WD_LIMIT = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] div = 16'd1;
    logic        rx = 1'b1;
    logic [7:0]  data;
    logic        valid, ferr, nerr;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int vcount = 0;
    int pulse_err = 0;
    int v_cyc = 0;
    int t0 = 0;
    logic valid_prev = 1'b0;

    always #2.5 clk = ~clk;

    uart_vote_rx #(.DATA_BITS(8), .OSR(16), .DIV_W(16)) u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .div_i       (div),
        .rx_i        (rx),
        .data_o      (data),
        .valid_o     (valid),
        .frame_err_o (ferr),
        .noise_err_o (nerr)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= WD_LIMIT) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, actual cycle %0d expected below %0d", cyc, WD_LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (valid) begin
            vcount = vcount + 1;
            v_cyc  = cyc;
            if (valid_prev) pulse_err = pulse_err + 1;
        end
        valid_prev = valid;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drives one frame; gbit/gsmp invert the single line level read by that sample (R3)
    task automatic send_frame(input int n, input logic [7:0] b, input logic stopv,
                              input int gbit, input int gsmp);
        for (int t = 0; t < 160 * n; t++) begin
            int   bi;
            logic v;
            bi = t / (16 * n);
            if (bi == 0)      v = 1'b0;
            else if (bi <= 8) v = b[bi-1];
            else              v = stopv;
            if (gbit >= 0 && t == gbit * 16 * n + (gsmp + 1) * n) v = ~v;
            @(negedge clk);
            rx = v;
            if (t == 0) t0 = cyc;
        end
        for (int t = 0; t < 4 * n; t++) begin
            @(negedge clk);
            rx = 1'b1;
        end
    endtask

    task automatic frame_check(input int n, input logic [7:0] b, input logic stopv,
                               input int gbit, input int gsmp);
        int vc0;
        vc0 = vcount;
        div = 16'(n - 1);
        send_frame(n, b, stopv, gbit, gsmp);
        chk("R2 strobe count", 32'(vcount), 32'(vc0 + 1));
        chk("R2 R3 data", 32'(data), 32'(b));
        chk("R1 strobe cycle", 32'(v_cyc), 32'(t0 + 3 + 154 * n));
        chk("R4 noise flag", 32'(nerr), (gbit >= 0) ? 32'd1 : 32'd0);
        chk("R5 frame flag", 32'(ferr), stopv ? 32'd0 : 32'd1);
    endtask

    // Low pulse of lo_len clocks, optional extra low level at spike (R6)
    task automatic false_start(input int n, input int lo_len, input int spike);
        int vc0;
        vc0 = vcount;
        div = 16'(n - 1);
        for (int t = 0; t < 160 * n; t++) begin
            @(negedge clk);
            rx = (t < lo_len || t == spike) ? 1'b0 : 1'b1;
        end
        chk("R6 no strobe on false start", 32'(vcount), 32'(vc0));
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R8: values under and just after reset
        chk("R8 valid at reset", 32'(valid), 32'd0);
        chk("R8 data at reset", 32'(data), 32'd0);
        chk("R8 flags at reset", 32'({ferr, nerr}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 valid after reset", 32'(valid), 32'd0);

        // R9: steady high line
        repeat (1000) @(negedge clk);
        chk("R9 idle line gives no strobe", 32'(vcount), 32'd0);

        // R1 R2: every byte at divider 1
        for (int b = 0; b < 256; b++) frame_check(2, 8'(b), 1'b1, -1, 0);
        // R1: other dividers
        for (int k = 0; k < 16; k++) frame_check(1, 8'(k * 17 + 3), 1'b1, -1, 0);
        for (int k = 0; k < 8; k++)  frame_check(6, 8'(8'h5A ^ (k * 37)), 1'b1, -1, 0);

        // R3 R4: single-sample inversion on every bit and every sample slot
        for (int gb = 0; gb < 10; gb++)
            for (int gs = 7; gs <= 9; gs++)
                frame_check(3, 8'(8'hA5 ^ (gb * 16 + gs)), 1'b1, gb, gs);

        // R3: an inversion just outside the sample window is not noise
        begin
            int vc0;
            vc0 = vcount;
            send_frame(3, 8'h96, 1'b1, 4, 5);
            chk("R3 outside window no noise", 32'(nerr), 32'd0);
            chk("R3 outside window data", 32'(data), 32'h96);
            chk("R3 outside window strobe", 32'(vcount), 32'(vc0 + 1));
        end

        // R5: stop bit low, then R7 hold
        frame_check(3, 8'h3C, 1'b0, -1, 0);
        begin
            int vc0;
            vc0 = vcount;
            repeat (500) @(negedge clk);
            chk("R7 data held", 32'(data), 32'h3C);
            chk("R7 flags held", 32'({ferr, nerr}), 32'b10);
            chk("R7 no strobe while idle", 32'(vcount), 32'(vc0));
        end
        // R4 R5: low stop with noise on it
        frame_check(3, 8'hC3, 1'b0, 9, 8);
        // R7: clean frame clears both flags
        frame_check(3, 8'h01, 1'b1, -1, 0);
        chk("R7 flags cleared", 32'({ferr, nerr}), 32'd0);

        // R6: short low pulse and a noisy short start
        false_start(3, 9, -1);
        false_start(3, 6, 27);
        chk("R7 data kept after false start", 32'(data), 32'h01);
        frame_check(3, 8'h7E, 1'b1, -1, 0);

        chk("R2 strobe width", 32'(pulse_err), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule